// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Glue

This block joins two eight-input interrupt controllers into a sixteen-line system. One controller is the primary and one is the secondary. Each controller reports its highest eligible input, if it has one, together with the upper five bits of its vector base. The controllers' own masking, priority and in-service logic is outside this block.

When the secondary has an eligible input and has not already raised, the block marks it raised. It then sends a single-cycle pulse toward primary input 2, the cascade input. The processor interrupt line follows the primary's raised flag.

On a processor acknowledge strobe, the block resolves the 8-bit vector and registers it. It then routes the acknowledge in one of two ways:
- A vector whose upper bits match the secondary base acknowledges the secondary input and also primary input 2.
- Any other vector acknowledges the primary input alone.

An acknowledge clears the matching raised flags, so both controllers are evaluated again on the next cycle.

Top module: `pic_cascade_glue`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to 0 after that edge.
- R2: When `slv_elig` is 1 and the secondary is not raised, the secondary becomes raised and `casc_pulse` is 1 for exactly the following cycle. No further pulse follows while the secondary stays raised.
- R3: The secondary's raised flag is cleared only by an acknowledge routed to the secondary. If `slv_elig` is still 1, a new `casc_pulse` follows one cycle after that acknowledge. An acknowledge routed to the primary alone produces no pulse.
- R4: `cpu_intr` rises the cycle after `mst_elig` is seen with the primary not raised. It stays high until an acknowledge.
- R5: On an `inta` edge, if `mst_elig` is 1 and `mst_pin` is not 2, `vec_out` becomes `{mst_base, mst_pin}`.
- R6: On an `inta` edge, if `mst_elig` is 1 and `mst_pin` is 2, `vec_out` becomes `{slv_base, slv_pin}` when `slv_elig` is 1.
- R7: The spurious vector uses pin 7 in two cases:
  - When `mst_elig` is 0, the vector is `{mst_base, 3'd7}`.
  - When the primary points at pin 2 but `slv_elig` is 0, the vector is `{slv_base, 3'd7}`.
- R8: Routing depends on the registered vector's upper five bits:
  - If they equal `slv_base`, then `slv_ack` is 1 with `slv_ack_pin` equal to the vector's low three bits, and `mst_ack` is 1 with `mst_ack_pin` equal to 2.
  - Otherwise `slv_ack` is 0, and `mst_ack` is 1 with `mst_ack_pin` equal to the low three bits.
  - Acknowledge outputs last one cycle.
- R9: `vec_vld` is 1 for exactly the cycle after each `inta` edge. `vec_out` holds its value until the next `inta`.
- R10: An acknowledge clears the primary raised flag at the same edge. `cpu_intr` is therefore low for one cycle before re-rising while `mst_elig` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_elig | input | 1 | Primary controller has an eligible input |
| mst_pin | input | 3 | Primary's highest eligible input |
| mst_base | input | 5 | Primary vector base, upper five bits |
| slv_elig | input | 1 | Secondary controller has an eligible input |
| slv_pin | input | 3 | Secondary's highest eligible input |
| slv_base | input | 5 | Secondary vector base, upper five bits |
| inta | input | 1 | Processor acknowledge strobe, one cycle |
| cpu_intr | output | 1 | Interrupt request to the processor |
| casc_pulse | output | 1 | One-cycle pulse toward primary input 2 |
| vec_vld | output | 1 | Vector valid, one cycle after `inta` |
| vec_out | output | 8 | Resolved vector, held until the next `inta` |
| mst_ack | output | 1 | Acknowledge to the primary |
| mst_ack_pin | output | 3 | Primary input being acknowledged |
| slv_ack | output | 1 | Acknowledge to the secondary |
| slv_ack_pin | output | 3 | Secondary input being acknowledged |

## Verification
The assertions check several things on every cycle:
- the cascade pulse lasts one cycle and only follows secondary eligibility;
- the interrupt line falls only after an acknowledge;
- the vector holds between strobes;
- a secondary acknowledge always comes paired with a primary acknowledge of input 2, and each acknowledge pin agrees with the registered vector.

Which vector source is chosen (primary, secondary, or one of the two spurious forms) can only be shown by the bench's scenarios and its reference model. The same holds for the re-raise one cycle after an acknowledge, and for a primary-only acknowledge leaving the secondary's raised state alone.

// File: rtl/pic_cascade_pkg.sv
// Package: shared defaults for the cascade glue.
// Assumes eight inputs per controller and an 8-bit vector.
package pic_cascade_pkg;
    parameter int PCG_PIN_W    = 3;
    parameter int PCG_VEC_W    = 8;
    parameter int PCG_CASC_PIN = 2;
    parameter int PCG_NUM_CTL  = 2;
    localparam int PCG_IDX_MST = 0;
    localparam int PCG_IDX_SLV = 1;
endpackage

// File: rtl/pcg_raise_flag.sv
// Module: per-controller raised flag.
// Set when the controller has an eligible input; cleared by an acknowledge.
// Assumes: clear wins over set in the same cycle.
module pcg_raise_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic elig_i,
    input  logic clr_i,
    output logic raised_o
);
    // Track whether this controller has already signalled its request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raised_o <= 1'b0;
        else if (clr_i)
            raised_o <= 1'b0;
        else if (elig_i)
            raised_o <= 1'b1;
    end
endmodule

// File: rtl/pcg_vector_pick.sv
// Module: combinational vector resolution.
// Uses the secondary when the primary points at the cascade input, and the
// all-ones pin of the chosen controller when nothing is eligible.
// Assumes: bases are the upper bits of the vector.
module pcg_vector_pick #(
    parameter int PIN_W    = 3,
    parameter int BASE_W   = 5,
    parameter int CASC_PIN = 2
) (
    input  logic                      mst_elig,
    input  logic [PIN_W-1:0]          mst_pin,
    input  logic [BASE_W-1:0]         mst_base,
    input  logic                      slv_elig,
    input  logic [PIN_W-1:0]          slv_pin,
    input  logic [BASE_W-1:0]         slv_base,
    output logic [BASE_W+PIN_W-1:0]   vec
);
    localparam logic [PIN_W-1:0] SPUR = {PIN_W{1'b1}};
    localparam logic [PIN_W-1:0] CASC = PIN_W'(CASC_PIN);

    logic              use_slv;
    logic [PIN_W-1:0]  pick_pin;
    logic [BASE_W-1:0] pick_base;

    // Select source controller and pin, falling back to the spurious pin.
    always_comb begin
        use_slv = mst_elig && (mst_pin == CASC);
        if (use_slv) begin
            pick_base = slv_base;
            pick_pin  = slv_elig ? slv_pin : SPUR;
        end else begin
            pick_base = mst_base;
            pick_pin  = mst_elig ? mst_pin : SPUR;
        end
        vec = {pick_base, pick_pin};
    end
endmodule

// File: rtl/pcg_ack_route.sv
// Module: decide which controllers an acknowledged vector belongs to.
// A vector in the secondary's range hits the secondary pin and the
// primary cascade input; any other hits the primary pin alone.
module pcg_ack_route #(
    parameter int PIN_W    = 3,
    parameter int BASE_W   = 5,
    parameter int CASC_PIN = 2
) (
    input  logic [BASE_W+PIN_W-1:0] vec,
    input  logic [BASE_W-1:0]       slv_base,
    output logic                    to_slv,
    output logic [PIN_W-1:0]        slv_pin,
    output logic [PIN_W-1:0]        mst_pin
);
    // Compare the vector's base field against the secondary base.
    always_comb begin
        to_slv  = (vec[BASE_W+PIN_W-1:PIN_W] == slv_base);
        slv_pin = vec[PIN_W-1:0];
        mst_pin = to_slv ? PIN_W'(CASC_PIN) : vec[PIN_W-1:0];
    end
endmodule

// File: rtl/pic_cascade_glue.sv
// Module: cascade glue between a primary and a secondary 8-input controller.
// Forwards a secondary raise as a one-cycle pulse, resolves and registers
// the vector on an acknowledge strobe, and routes that acknowledge.
// Assumes: eligibility inputs already include each controller's masking
// and priority; inta is a single-cycle strobe.
module pic_cascade_glue #(
    parameter int PIN_W    = pic_cascade_pkg::PCG_PIN_W,
    parameter int VEC_W    = pic_cascade_pkg::PCG_VEC_W,
    parameter int CASC_PIN = pic_cascade_pkg::PCG_CASC_PIN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mst_elig,
    input  logic [PIN_W-1:0]        mst_pin,
    input  logic [VEC_W-PIN_W-1:0]  mst_base,
    input  logic                    slv_elig,
    input  logic [PIN_W-1:0]        slv_pin,
    input  logic [VEC_W-PIN_W-1:0]  slv_base,
    input  logic                    inta,
    output logic                    cpu_intr,
    output logic                    casc_pulse,
    output logic                    vec_vld,
    output logic [VEC_W-1:0]        vec_out,
    output logic                    mst_ack,
    output logic [PIN_W-1:0]        mst_ack_pin,
    output logic                    slv_ack,
    output logic [PIN_W-1:0]        slv_ack_pin
);
    import pic_cascade_pkg::*;

    localparam int BASE_W = VEC_W - PIN_W;
    localparam int NCTL   = PCG_NUM_CTL;

    logic [VEC_W-1:0] vec_now;
    logic             route_slv;
    logic [PIN_W-1:0] route_slv_pin;
    logic [PIN_W-1:0] route_mst_pin;
    logic [NCTL-1:0]  elig_v;
    logic [NCTL-1:0]  clr_v;
    logic [NCTL-1:0]  raised_v;
    logic             casc_q;

    pcg_vector_pick #(.PIN_W(PIN_W), .BASE_W(BASE_W), .CASC_PIN(CASC_PIN)) u_pick (
        .mst_elig (mst_elig),
        .mst_pin  (mst_pin),
        .mst_base (mst_base),
        .slv_elig (slv_elig),
        .slv_pin  (slv_pin),
        .slv_base (slv_base),
        .vec      (vec_now)
    );

    pcg_ack_route #(.PIN_W(PIN_W), .BASE_W(BASE_W), .CASC_PIN(CASC_PIN)) u_route (
        .vec      (vec_now),
        .slv_base (slv_base),
        .to_slv   (route_slv),
        .slv_pin  (route_slv_pin),
        .mst_pin  (route_mst_pin)
    );

    // Per-controller eligibility and acknowledge-clear vectors.
    always_comb begin
        elig_v[PCG_IDX_MST] = mst_elig;
        elig_v[PCG_IDX_SLV] = slv_elig;
        clr_v[PCG_IDX_MST]  = inta;
        clr_v[PCG_IDX_SLV]  = inta & route_slv;
    end

    genvar g;
    generate
        for (g = 0; g < NCTL; g++) begin : g_flag
            pcg_raise_flag u_flag (
                .clk      (clk),
                .rst_n    (rst_n),
                .elig_i   (elig_v[g]),
                .clr_i    (clr_v[g]),
                .raised_o (raised_v[g])
            );
        end
    endgenerate

    // Cascade pulse: fires on the edge at which the secondary becomes raised.
    always_ff @(posedge clk) begin
        if (!rst_n)
            casc_q <= 1'b0;
        else
            casc_q <= elig_v[PCG_IDX_SLV] & ~raised_v[PCG_IDX_SLV] & ~clr_v[PCG_IDX_SLV];
    end

    // Register the resolved vector and the one-cycle acknowledge outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out     <= '0;
            vec_vld     <= 1'b0;
            mst_ack     <= 1'b0;
            mst_ack_pin <= '0;
            slv_ack     <= 1'b0;
            slv_ack_pin <= '0;
        end else begin
            vec_vld <= inta;
            mst_ack <= inta;
            slv_ack <= inta & route_slv;
            if (inta) begin
                vec_out     <= vec_now;
                mst_ack_pin <= route_mst_pin;
                slv_ack_pin <= route_slv ? route_slv_pin : '0;
            end
        end
    end

    assign cpu_intr   = raised_v[PCG_IDX_MST];
    assign casc_pulse = casc_q;
endmodule

// File: rtl/pic_cascade_glue_chk.sv
// Module: property checker for pic_cascade_glue, attached by bind.
// Assumes the same parameters and port names as the top module.
module pic_cascade_glue_chk #(
    parameter int PIN_W    = 3,
    parameter int VEC_W    = 8,
    parameter int CASC_PIN = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mst_elig,
    input logic [PIN_W-1:0]       mst_pin,
    input logic [VEC_W-PIN_W-1:0] mst_base,
    input logic                   slv_elig,
    input logic [PIN_W-1:0]       slv_pin,
    input logic [VEC_W-PIN_W-1:0] slv_base,
    input logic                   inta,
    input logic                   cpu_intr,
    input logic                   casc_pulse,
    input logic                   vec_vld,
    input logic [VEC_W-1:0]       vec_out,
    input logic                   mst_ack,
    input logic [PIN_W-1:0]       mst_ack_pin,
    input logic                   slv_ack,
    input logic [PIN_W-1:0]       slv_ack_pin
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!cpu_intr && !casc_pulse && !vec_vld && !mst_ack && !slv_ack));

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        casc_pulse |=> !casc_pulse);

    assert_pulse_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        casc_pulse |-> $past(slv_elig));

    assert_intr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_intr) |-> $past(inta));

    assert_vld_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> $past(inta));

    assert_vec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |=> $stable(vec_out));

    assert_slave_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack |-> (mst_ack && mst_ack_pin == PIN_W'(CASC_PIN)));

    assert_slave_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack |-> (slv_ack_pin == vec_out[PIN_W-1:0]));

    assert_master_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_vld && !slv_ack) |-> (mst_ack && mst_ack_pin == vec_out[PIN_W-1:0]));
endmodule

bind pic_cascade_glue pic_cascade_glue_chk #(
    .PIN_W(PIN_W), .VEC_W(VEC_W), .CASC_PIN(CASC_PIN)
) u_chk (.*);

// File: tb/pic_cascade_glue_bench.sv
// Bench: behavioural reference model updated on each rising edge and
// compared against every output at each falling edge, plus directed checks.
module pic_cascade_glue_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mst_elig = 1'b0;
    logic [2:0] mst_pin = '0;
    logic [4:0] mst_base = '0;
    logic       slv_elig = 1'b0;
    logic [2:0] slv_pin = '0;
    logic [4:0] slv_base = '0;
    logic       inta = 1'b0;
    logic       cpu_intr, casc_pulse, vec_vld, mst_ack, slv_ack;
    logic [7:0] vec_out;
    logic [2:0] mst_ack_pin, slv_ack_pin;

    int total = 0;
    int bad = 0;

    // Reference model state (expected outputs)
    int m_raised = 0, s_raised = 0;
    int e_casc = 0, e_vld = 0, e_vec = 0, e_mack = 0, e_mpin = 0, e_sack = 0, e_spin = 0;
    string e_tag = "R9";

    always #10 clk = ~clk;

    pic_cascade_glue u_pic_cascade_glue (
        .clk(clk), .rst_n(rst_n),
        .mst_elig(mst_elig), .mst_pin(mst_pin), .mst_base(mst_base),
        .slv_elig(slv_elig), .slv_pin(slv_pin), .slv_base(slv_base),
        .inta(inta), .cpu_intr(cpu_intr), .casc_pulse(casc_pulse),
        .vec_vld(vec_vld), .vec_out(vec_out),
        .mst_ack(mst_ack), .mst_ack_pin(mst_ack_pin),
        .slv_ack(slv_ack), .slv_ack_pin(slv_ack_pin)
    );

    // Reference model: arithmetic on integers, updated at each rising edge.
    always @(posedge clk) begin
        int pin, base;
        if (!rst_n) begin
            m_raised = 0; s_raised = 0; e_casc = 0; e_vld = 0; e_vec = 0;
            e_mack = 0; e_mpin = 0; e_sack = 0; e_spin = 0;
        end else begin
            e_casc = 0; e_vld = 0; e_mack = 0; e_sack = 0;
            if (inta) begin
                if (mst_elig && mst_pin == 2) begin
                    base = slv_base;
                    pin  = slv_elig ? int'(slv_pin) : 7;
                    e_tag = slv_elig ? "R6" : "R7";
                end else begin
                    base = mst_base;
                    pin  = mst_elig ? int'(mst_pin) : 7;
                    e_tag = mst_elig ? "R5" : "R7";
                end
                e_vec = base * 8 + pin;
                e_vld = 1;
                e_mack = 1;
                if (e_vec / 8 == int'(slv_base)) begin
                    e_sack = 1; e_spin = e_vec % 8; e_mpin = 2;
                end else begin
                    e_spin = 0; e_mpin = e_vec % 8;
                end
            end
            if (inta && e_sack == 1) s_raised = 0;
            else if (slv_elig && s_raised == 0) begin s_raised = 1; e_casc = 1; end
            if (inta) m_raised = 0;
            else if (mst_elig) m_raised = 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R4", "cpu_intr", int'(cpu_intr), m_raised);
        check("R2", "casc_pulse", int'(casc_pulse), e_casc);
        check("R9", "vec_vld", int'(vec_vld), e_vld);
        check(e_tag, "vec_out", int'(vec_out), e_vec);
        check("R8", "mst_ack", int'(mst_ack), e_mack);
        check("R8", "slv_ack", int'(slv_ack), e_sack);
        if (e_mack == 1) check("R8", "mst_ack_pin", int'(mst_ack_pin), e_mpin);
        if (e_sack == 1) check("R8", "slv_ack_pin", int'(slv_ack_pin), e_spin);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic strobe();
        inta = 1'b1;
        tick();
        inta = 1'b0;
    endtask

    task automatic run_all();
        // Reset state
        repeat (3) tick();
        check("R1", "cpu_intr", int'(cpu_intr), 0);
        check("R1", "vec_out", int'(vec_out), 0);
        check("R1", "acks", int'(mst_ack) + int'(slv_ack) + int'(casc_pulse), 0);
        rst_n = 1'b1;
        mst_base = 5'h01;
        slv_base = 5'h0E;
        tick();

        // Primary-only request and acknowledge
        mst_elig = 1'b1; mst_pin = 3'd5;
        tick();
        check("R4", "cpu_intr rise", int'(cpu_intr), 1);
        tick();
        strobe();
        check("R5", "vector primary", int'(vec_out), 8'h0D);
        check("R10", "cpu_intr drop", int'(cpu_intr), 0);
        check("R8", "primary pin", int'(mst_ack_pin), 5);
        tick();
        check("R10", "cpu_intr reraise", int'(cpu_intr), 1);
        check("R9", "vec held", int'(vec_out), 8'h0D);

        // Secondary request through the cascade input
        slv_elig = 1'b1; slv_pin = 3'd3;
        tick();
        check("R2", "cascade pulse", int'(casc_pulse), 1);
        tick();
        check("R2", "no repeat pulse", int'(casc_pulse), 0);
        strobe();
        tick();
        check("R3", "no pulse after primary ack", int'(casc_pulse), 0);
        mst_pin = 3'd2;
        tick();
        strobe();
        check("R6", "vector secondary", int'(vec_out), 8'h73);
        check("R8", "secondary ack", int'(slv_ack), 1);
        check("R8", "secondary pin", int'(slv_ack_pin), 3);
        check("R8", "cascade ack pin", int'(mst_ack_pin), 2);
        tick();
        check("R3", "pulse after secondary ack", int'(casc_pulse), 1);

        // Spurious cases
        slv_elig = 1'b0;
        tick();
        strobe();
        check("R7", "spurious secondary", int'(vec_out), 8'h77);
        check("R8", "spurious secondary pin", int'(slv_ack_pin), 7);
        mst_elig = 1'b0;
        tick(); tick();
        strobe();
        check("R7", "spurious primary", int'(vec_out), 8'h0F);
        check("R8", "spurious primary no slv", int'(slv_ack), 0);
        tick();

        // Mixed patterns, model compared each cycle
        for (int i = 0; i < 600; i++) begin
            mst_elig = 1'($urandom_range(0, 1));
            mst_pin  = 3'($urandom_range(0, 7));
            slv_elig = 1'($urandom_range(0, 1));
            slv_pin  = 3'($urandom_range(0, 7));
            inta     = ($urandom_range(0, 3) == 0);
            if (i == 300) begin mst_base = 5'h04; slv_base = 5'h05; end
            tick();
        end
        inta = 1'b0;
        tick();
    endtask

    initial begin
        bit wd_hit;
        wd_hit = 1'b0;
        fork
            run_all();
            begin repeat (100000) @(posedge clk); wd_hit = 1'b1; end
        join_any
        disable fork;
        if (wd_hit) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule